// File: doc/BRIEF.md
# Dual-Mode Compare PWM Generator

This block produces one pulse-width-modulated output from two compare values. The first is the mark value, which gives the set or duty point. The second is the span value, which gives the period or the clear point. The block runs in one of two alignment modes.

- **Edge-aligned mode.** An internal counter steps from zero up to the span value and wraps. The output is high from count zero until the count reaches the mark value. The counter advances on a clock-enable tick from a prescaler, which divides the clock by 1, 4, 8 or 64.
- **Center-aligned mode.** The period comes from an external timer, which supplies its running count and its period limit. The output is set when that count equals the mark value and cleared when it equals the span value.

Software may write either compare value at any time. Each write goes into a staging register. The active (shadow) copy used by the compare logic is reloaded from staging only at a period boundary, so a duty change never produces a runt pulse. The block raises a one-cycle period-end strobe on the same cycle that the shadows take their new values. While the block is disabled, the output is held low, the counter and prescaler are cleared, and the shadows follow the staging registers. The first period after enable therefore uses the values written most recently.

Top module: `cmp_pwm_gen`

## Requirements
- R1: While `en` is low, `pwm_out` and `period_end` are 0 one cycle later, and the edge counter and prescaler are cleared. A run therefore restarts from count zero after `en` rises.
- R2: In edge-aligned mode (`align_mode`=0) the counter holds values 0 to span inclusive and wraps to 0 on the tick where it equals span. `pwm_out` is registered: in each cycle it shows whether the count in the previous cycle was below mark.
- R3: `presc_sel` gives the number of enabled cycles per counter step: 2'b00 gives 1, 2'b01 gives 4, 2'b10 gives 8 and 2'b11 gives 64. The first step comes that many cycles after `en` rises.
- R4: In edge-aligned mode, an active mark of 0 keeps `pwm_out` low for the whole period (0% duty).
- R5: In edge-aligned mode, an active mark greater than the active span keeps `pwm_out` high for the whole period (100% duty).
- R6: In center-aligned mode (`align_mode`=1) `pwm_out` is set on the cycle after `sync_count` equals mark and cleared on the cycle after it equals span. Clearing wins when mark equals span. Otherwise the output holds its level.
- R7: In center-aligned mode, active mark, active span and `sync_period` all zero keep `pwm_out` low.
- R8: In center-aligned mode, an active span greater than `sync_period` keeps `pwm_out` high.
- R9: Writes to mark or span reach the compare logic only at a period end. The shadows load on the edge that raises `period_end`, and `period_end` is high for one cycle for each boundary.
- R10: In center-aligned mode, a period end occurs on the first cycle in which `sync_count` equals `sync_period` after a cycle in which they differed (or after enable).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Block enable |
| align_mode | input | 1 | 0 = edge-aligned, 1 = center-aligned |
| presc_sel | input | 2 | Prescaler select (1, 4, 8, 64) |
| wr_mark | input | 1 | Write strobe for the mark staging register |
| mark_data | input | CNT_W | Mark value to stage |
| wr_span | input | 1 | Write strobe for the span staging register |
| span_data | input | CNT_W | Span value to stage |
| sync_count | input | CNT_W | External timer count (center mode) |
| sync_period | input | CNT_W | External timer period limit (center mode) |
| pwm_out | output | 1 | Registered PWM output |
| period_end | output | 1 | One-cycle period-boundary strobe |

## Verification
The hardest situation to reach is a compare write that lands in the middle of a period, whose effect must appear on the cycle after the next boundary and not before. The bench writes new mark and span values at chosen offsets inside running periods, under several prescaler settings.

The bench also writes values that move the block across the 0% and 100% boundaries. A behavioural model, compared on every clock, holds the staged and active copies apart. Any early or late load therefore shows up as a mismatch on `pwm_out` or `period_end`.

// File: rtl/cmp_pwm_pkg.sv
package cmp_pwm_pkg;
  typedef enum logic {
    ALIGN_EDGE   = 1'b0,
    ALIGN_CENTER = 1'b1
  } align_e;

  typedef enum logic [1:0] {
    PS_DIV1  = 2'd0,
    PS_DIV4  = 2'd1,
    PS_DIV8  = 2'd2,
    PS_DIV64 = 2'd3
  } presc_e;

  function automatic int unsigned presc_div(logic [1:0] sel);
    case (sel)
      PS_DIV1:  return 1;
      PS_DIV4:  return 4;
      PS_DIV8:  return 8;
      default:  return 64;
    endcase
  endfunction
endpackage

// File: rtl/cmp_pwm_prescale.sv
module cmp_pwm_prescale #(
  parameter int PS_W = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run_i,
  input  logic [1:0] sel_i,
  output logic       tick_o
);
  import cmp_pwm_pkg::*;

  logic [PS_W-1:0] pcnt_q;
  logic [PS_W-1:0] lim;

  always_comb lim = PS_W'(presc_div(sel_i) - 1);

  assign tick_o = run_i && (pcnt_q >= lim);

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      pcnt_q <= '0;
    end else if (tick_o) begin
      pcnt_q <= '0;
    end else begin
      pcnt_q <= pcnt_q + 1'b1;
    end
  end

  // R3: with any division above one, ticks never come back to back
  p_tick_gap_r3: assert property (@(posedge clk) disable iff (rst)
    (run_i && sel_i != 2'd0 && tick_o) |=> (!tick_o || sel_i != $past(sel_i)));
endmodule

// File: rtl/cmp_pwm_regs.sv
module cmp_pwm_regs #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             load_i,
  input  logic             wr_mark_i,
  input  logic [CNT_W-1:0] mark_d_i,
  input  logic             wr_span_i,
  input  logic [CNT_W-1:0] span_d_i,
  output logic [CNT_W-1:0] mark_o,
  output logic [CNT_W-1:0] span_o
);
  logic [CNT_W-1:0] stage_mark_q, stage_span_q;
  logic [CNT_W-1:0] act_mark_q, act_span_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_mark_q <= '0;
      stage_span_q <= '0;
    end else begin
      if (wr_mark_i) stage_mark_q <= mark_d_i;
      if (wr_span_i) stage_span_q <= span_d_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_mark_q <= '0;
      act_span_q <= '0;
    end else if (!run_i || load_i) begin
      act_mark_q <= stage_mark_q;
      act_span_q <= stage_span_q;
    end
  end

  assign mark_o = act_mark_q;
  assign span_o = act_span_q;
endmodule

// File: rtl/cmp_pwm_timebase.sv
module cmp_pwm_timebase #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             mode_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] span_i,
  input  logic [CNT_W-1:0] sync_cnt_i,
  input  logic [CNT_W-1:0] sync_per_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o,
  output logic             pe_o
);
  import cmp_pwm_pkg::*;

  logic [CNT_W-1:0] cnt_q;
  logic             match_q;
  logic             pe_q;
  logic             sync_match;
  logic             edge_wrap;
  logic             ctr_wrap;

  assign sync_match = (sync_cnt_i == sync_per_i);
  assign edge_wrap  = tick_i && (cnt_q == span_i);
  assign ctr_wrap   = sync_match && !match_q;
  assign wrap_o     = run_i && ((mode_i == ALIGN_CENTER) ? ctr_wrap : edge_wrap);

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      cnt_q   <= '0;
      match_q <= 1'b0;
      pe_q    <= 1'b0;
    end else begin
      pe_q    <= wrap_o;
      match_q <= sync_match;
      if (mode_i == ALIGN_CENTER) begin
        cnt_q <= '0;
      end else if (tick_i) begin
        cnt_q <= edge_wrap ? '0 : cnt_q + 1'b1;
      end
    end
  end

  assign cnt_o = cnt_q;
  assign pe_o  = pe_q;

  // R2: edge counter never passes the active span
  p_cnt_in_range_r2: assert property (@(posedge clk) disable iff (rst)
    (run_i && mode_i == ALIGN_EDGE) |-> (cnt_q <= span_i));
endmodule

// File: rtl/cmp_pwm_wave.sv
module cmp_pwm_wave #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             mode_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] mark_i,
  input  logic [CNT_W-1:0] span_i,
  input  logic [CNT_W-1:0] sync_cnt_i,
  input  logic [CNT_W-1:0] sync_per_i,
  output logic             pwm_o
);
  import cmp_pwm_pkg::*;

  logic pwm_q;
  logic edge_lvl;
  logic ctr_lvl;
  logic all_zero;

  assign all_zero = (mark_i == '0) && (span_i == '0) && (sync_per_i == '0);

  always_comb begin
    if (mark_i == '0)        edge_lvl = 1'b0;
    else if (mark_i > span_i) edge_lvl = 1'b1;
    else                     edge_lvl = (cnt_i < mark_i);
  end

  always_comb begin
    if (all_zero)                   ctr_lvl = 1'b0;
    else if (span_i > sync_per_i)   ctr_lvl = 1'b1;
    else if (sync_cnt_i == span_i)  ctr_lvl = 1'b0;
    else if (sync_cnt_i == mark_i)  ctr_lvl = 1'b1;
    else                            ctr_lvl = pwm_q;
  end

  always_ff @(posedge clk) begin
    if (rst || !run_i) pwm_q <= 1'b0;
    else               pwm_q <= (mode_i == ALIGN_CENTER) ? ctr_lvl : edge_lvl;
  end

  assign pwm_o = pwm_q;

  p_idle_low_r1: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> !pwm_q);
  p_edge_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (run_i && mode_i == ALIGN_EDGE && mark_i == '0) |=> !pwm_q);
  p_edge_full_r5: assert property (@(posedge clk) disable iff (rst)
    (run_i && mode_i == ALIGN_EDGE && mark_i > span_i) |=> pwm_q);
  p_ctr_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (run_i && mode_i == ALIGN_CENTER && all_zero) |=> !pwm_q);
  p_ctr_full_r8: assert property (@(posedge clk) disable iff (rst)
    (run_i && mode_i == ALIGN_CENTER && span_i > sync_per_i) |=> pwm_q);
endmodule

// File: rtl/cmp_pwm_gen.sv
module cmp_pwm_gen #(
  parameter int CNT_W = 16,
  parameter int PS_W  = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             align_mode,
  input  logic [1:0]       presc_sel,
  input  logic             wr_mark,
  input  logic [CNT_W-1:0] mark_data,
  input  logic             wr_span,
  input  logic [CNT_W-1:0] span_data,
  input  logic [CNT_W-1:0] sync_count,
  input  logic [CNT_W-1:0] sync_period,
  output logic             pwm_out,
  output logic             period_end
);
  logic             tick;
  logic             wrap;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] mark_act, span_act;

  cmp_pwm_prescale #(.PS_W(PS_W)) u_presc (
    .clk(clk), .rst(rst), .run_i(en), .sel_i(presc_sel), .tick_o(tick)
  );

  cmp_pwm_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .run_i(en), .load_i(wrap),
    .wr_mark_i(wr_mark), .mark_d_i(mark_data),
    .wr_span_i(wr_span), .span_d_i(span_data),
    .mark_o(mark_act), .span_o(span_act)
  );

  cmp_pwm_timebase #(.CNT_W(CNT_W)) u_tbase (
    .clk(clk), .rst(rst), .run_i(en), .mode_i(align_mode), .tick_i(tick),
    .span_i(span_act), .sync_cnt_i(sync_count), .sync_per_i(sync_period),
    .cnt_o(cnt), .wrap_o(wrap), .pe_o(period_end)
  );

  cmp_pwm_wave #(.CNT_W(CNT_W)) u_wave (
    .clk(clk), .rst(rst), .run_i(en), .mode_i(align_mode), .cnt_i(cnt),
    .mark_i(mark_act), .span_i(span_act),
    .sync_cnt_i(sync_count), .sync_per_i(sync_period), .pwm_o(pwm_out)
  );

  // R9: active compare values change only on a boundary edge
  p_shadow_hold_r9: assert property (@(posedge clk) disable iff (rst)
    en |=> (period_end || ($stable(mark_act) && $stable(span_act))));
  // R1: disabled block produces no strobe
  p_idle_nostrobe_r1: assert property (@(posedge clk) disable iff (rst)
    !en |=> !period_end);
endmodule

// File: tb/test_cmp_pwm_gen.sv
module test_cmp_pwm_gen;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic align_mode = 1'b0;
  logic [1:0] presc_sel = 2'd0;
  logic wr_mark = 1'b0, wr_span = 1'b0;
  logic [W-1:0] mark_data = '0, span_data = '0;
  logic [W-1:0] sync_count = '0, sync_period = '0;
  logic sync_run = 1'b0;
  logic pwm_out, period_end;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;
  string req = "R1";

  // behavioural reference state
  int m_pcnt = 0, m_cnt = 0, m_mq = 0, m_pe = 0, m_pwm = 0;
  int st_mark = 0, st_span = 0, sh_mark = 0, sh_span = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmp_pwm_gen #(.CNT_W(W)) i_cmp_pwm_gen (
    .clk(clk), .rst(rst), .en(en), .align_mode(align_mode),
    .presc_sel(presc_sel), .wr_mark(wr_mark), .mark_data(mark_data),
    .wr_span(wr_span), .span_data(span_data), .sync_count(sync_count),
    .sync_period(sync_period), .pwm_out(pwm_out), .period_end(period_end)
  );

  function automatic int divide_of(logic [1:0] s);
    case (s)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 64;
    endcase
  endfunction

  always @(posedge clk) begin
    int o_sm, o_ss, lvl, sc, sp;
    bit tick, match, wrap;
    o_sm = st_mark; o_ss = st_span;
    sc = int'(sync_count); sp = int'(sync_period);
    if (rst) begin
      m_pcnt = 0; m_cnt = 0; m_mq = 0; m_pe = 0; m_pwm = 0;
      st_mark = 0; st_span = 0; sh_mark = 0; sh_span = 0;
    end else begin
      if (!en) begin
        m_pcnt = 0; m_cnt = 0; m_mq = 0; m_pe = 0; m_pwm = 0;
        sh_mark = o_sm; sh_span = o_ss;
      end else begin
        tick  = (m_pcnt >= divide_of(presc_sel) - 1);
        match = (sc == sp);
        if (align_mode) begin
          wrap = match && (m_mq == 0);
          if (sh_mark == 0 && sh_span == 0 && sp == 0) lvl = 0;
          else if (sh_span > sp) lvl = 1;
          else if (sc == sh_span) lvl = 0;
          else if (sc == sh_mark) lvl = 1;
          else lvl = m_pwm;
        end else begin
          wrap = tick && (m_cnt == sh_span);
          if (sh_mark == 0) lvl = 0;
          else if (sh_mark > sh_span) lvl = 1;
          else lvl = (m_cnt < sh_mark) ? 1 : 0;
        end
        m_pwm = lvl;
        m_pcnt = tick ? 0 : m_pcnt + 1;
        if (align_mode) m_cnt = 0;
        else if (tick) m_cnt = (m_cnt == sh_span) ? 0 : m_cnt + 1;
        m_mq = match ? 1 : 0;
        m_pe = wrap ? 1 : 0;
        if (wrap) begin sh_mark = o_sm; sh_span = o_ss; end
      end
      if (wr_mark) st_mark = int'(mark_data);
      if (wr_span) st_span = int'(span_data);
    end
  end

  task automatic check(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", tag, what, act, exp, cycles);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    check(req, int'(pwm_out), m_pwm, "pwm_out");
    check(req, int'(period_end), m_pe, "period_end");
    if (sync_run) sync_count = (sync_count >= sync_period) ? '0 : sync_count + 1'b1;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic put_mark(int v);
    wr_mark = 1'b1; mark_data = W'(v); cyc(); wr_mark = 1'b0;
  endtask

  task automatic put_span(int v);
    wr_span = 1'b1; span_data = W'(v); cyc(); wr_span = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 60000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      summary();
      $finish;
    end
  end

  initial begin
    // R1: reset state
    req = "R1";
    run(3);
    check("R1", int'(pwm_out), 0, "reset pwm_out");
    check("R1", int'(period_end), 0, "reset period_end");
    rst = 1'b0;
    run(2);

    // R2: basic edge-aligned waveform, mark 3 span 9, div 1
    req = "R2";
    put_mark(3); put_span(9);
    cyc(); en = 1'b1;
    run(40);

    // R9: mid-period writes wait for the boundary
    req = "R9";
    run(4); put_mark(6); run(2); put_span(12);
    run(40);

    // R3: each prescaler division
    req = "R3";
    for (int s = 1; s < 4; s++) begin
      en = 1'b0; cyc();
      presc_sel = 2'(s); put_mark(2); put_span(3);
      en = 1'b1;
      run(divide_of(2'(s)) * 4 * 3 + 5);
    end
    en = 1'b0; cyc(); presc_sel = 2'd0; en = 1'b1;

    // R4: mark zero gives 0% duty
    req = "R4";
    put_mark(0); put_span(5);
    run(30);
    check("R4", int'(pwm_out), 0, "0% duty level");

    // R5: mark above span gives 100% duty
    req = "R5";
    put_mark(8);
    run(30);
    check("R5", int'(pwm_out), 1, "100% duty level");

    // R1: disable mid-run, then restart
    req = "R1";
    put_mark(2);
    run(7);
    en = 1'b0; run(3);
    check("R1", int'(pwm_out), 0, "disabled pwm_out");
    en = 1'b1; run(15);

    // R6 / R10: center-aligned with external timer
    req = "R6";
    en = 1'b0; cyc();
    align_mode = 1'b1; sync_period = W'(10); sync_count = '0; sync_run = 1'b1;
    put_mark(2); put_span(7);
    en = 1'b1;
    run(50);
    req = "R10";
    put_mark(4); run(3); put_span(9);
    run(40);
    req = "R6";
    put_mark(5); put_span(5);
    run(40);

    // R8: span above sync period
    req = "R8";
    put_span(12); put_mark(3);
    run(30);
    check("R8", int'(pwm_out), 1, "center 100% level");

    // R7: everything zero
    req = "R7";
    put_mark(0); put_span(0);
    run(15);
    en = 1'b0; cyc();
    sync_run = 1'b0; sync_period = '0; sync_count = '0;
    en = 1'b1;
    run(20);
    check("R7", int'(pwm_out), 0, "center all-zero level");

    done = 1;
    summary();
    $finish;
  end
endmodule